// File: doc/BRIEF.md
# Pilot tone frequency tracker

This block locks onto a single pilot tone in a stream of real, signed samples. It uses a Costas-style frequency/phase locked loop, and its output is the loop's current frequency estimate. That estimate is a phase increment: an unsigned fraction of one turn over 2^PW, and one increment is applied per accepted sample.

The loop has these stages:
- An oscillator made of a phase accumulator, which wraps at 2^PW, and a computed sine/cosine generator.
- Two mixers that use the oscillator's quadrature outputs to turn each sample into an in-phase product and a quadrature product.
- A matched first-order low-pass section on each path. Its passband sets the pull-in range.
- A second low-pass section on the in-phase path only. It adds the phase lag that the detector needs to sense frequency offset.
- The detector. Its error is the filtered quadrature value with its sign flipped whenever the lagged in-phase value is negative.
- A loop filter with two branches. One is a saturating integrator scaled down by 2^KI. The other is a proportional branch scaled up by 2^KP.

The increment sent to the oscillator, and out of the block, is the sum of a latched start value and both branches. With no tone present the error stays at zero and the output sits at the start value, so a downstream detector can compare two such trackers started on opposite sides of the expected pilot. The sample input is a valid/ready stream:
- A sample is consumed on a clock edge where both valid and ready are high.
- Ready drops only during a cycle in which the preset strobe is high.
- A source that raises valid keeps the sample and valid steady until it is consumed.
- While valid is low, nothing in the loop moves.

Top module: `pilot_tracker`

## Requirements
- R1: After asynchronous reset (rst_n low) and with preset low, inc_out is 0 and s_ready is 1.
- R2: A one-cycle preset strobe latches init_inc. From the next cycle, inc_out equals that value. Later changes on init_inc have no effect until the next preset, and a preset issued while tracking returns inc_out to the new start value at once.
- R3: s_ready is 0 in every cycle in which preset is 1, and a sample offered in that cycle is not consumed.
- R4: After a preset, inc_out stays exactly equal to the latched start value for as long as every consumed sample is zero.
- R5: In any cycle with no consumed sample and no preset, inc_out does not change, whatever s_data carries.
- R6: With defaults, start value 65536 and a consumed cosine tone of amplitude 1000 whose increment is 69632 (4096 above the start), the mean of inc_out over 512 samples that follow 6000 samples lies within 2048 of 69632.
- R7: Under the same conditions with a tone increment of 61440 (4096 below the start), the mean lies within 2048 of 61440.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| preset | input | 1 | Restart strobe: latches init_inc and clears phase, filters and integrator |
| init_inc | input | PW | Start increment, fraction of a turn over 2^PW |
| s_valid | input | 1 | Sample valid |
| s_ready | output | 1 | Sample ready, low during preset |
| s_data | input | DW | Signed two's-complement sample |
| inc_out | output | PW | Current phase increment (frequency estimate) |

## Verification
The checker assumes that the start value latched by preset comes from a single-cycle strobe. It also assumes that when a tone is present, samples arrive at a steady rate, so the loop dynamics are those of an unstalled stream. The integrator checks assume the detector error is small compared with the integrator range. This holds for any sample that fits in DW bits, because the error width is DW+2 and the integrator is PW+KI bits wide. The bench keeps to these assumptions: it issues presets as one-cycle pulses, and it drives tones at amplitude 1000 with valid high every cycle. It stalls the stream only outside the convergence windows, and while stalled it changes s_data freely.

// File: rtl/pilot_trk_pkg.sv
package pilot_trk_pkg;

  // Parabolic approximation of sin over one turn.
  // code: table address of tw bits, top bit selects the negative half.
  // Returns amp * 4h(H-h)/H^2 with H the half-turn span.
  function automatic int para_sine(input int unsigned code, input int tw, input int amp);
    longint half;
    longint h;
    longint y;
    half = longint'(1) << (tw - 1);
    h    = longint'(code) % half;
    y    = (longint'(4) * h * (half - h) * longint'(amp)) >> (2 * (tw - 1));
    if (((code >> (tw - 1)) & 32'd1) != 32'd0) return -int'(y);
    return int'(y);
  endfunction

endpackage

// File: rtl/pilot_iir.sv
module pilot_iir #(
  parameter int IW = 13,
  parameter int FR = 4,
  parameter int K  = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 en,
  input  logic signed [IW-1:0] d,
  output logic signed [IW-1:0] y
);
  localparam int STW = IW + FR;

  logic signed [STW-1:0] st_q;
  logic signed [STW:0]   diff;

  assign diff = ((STW+1)'(d) <<< FR) - (STW+1)'(st_q);
  assign y    = IW'(st_q >>> FR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   st_q <= '0;
    else if (clr) st_q <= '0;
    else if (en)  st_q <= st_q + STW'(diff >>> K);
  end
endmodule

// File: rtl/pilot_nco.sv
module pilot_nco
  import pilot_trk_pkg::*;
#(
  parameter int PW = 20,
  parameter int TW = 10,
  parameter int SW = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 adv,
  input  logic [PW-1:0]        inc,
  output logic signed [SW-1:0] sin_o,
  output logic signed [SW-1:0] cos_o
);
  localparam int AMP = 2 ** (SW - 1) - 1;
  localparam int QTR = 2 ** (TW - 2);

  logic [PW-1:0] phase_q;
  logic [TW-1:0] addr_s;
  logic [TW-1:0] addr_c;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    phase_q <= '0;
    else if (clr)  phase_q <= '0;
    else if (adv)  phase_q <= phase_q + inc;
  end

  assign addr_s = phase_q[PW-1 -: TW];
  assign addr_c = addr_s + TW'(QTR);
  assign sin_o  = SW'(para_sine(32'(addr_s), TW, AMP));
  assign cos_o  = SW'(para_sine(32'(addr_c), TW, AMP));
endmodule

// File: rtl/pilot_loop_filter.sv
module pilot_loop_filter #(
  parameter int PW = 20,
  parameter int EW = 14,
  parameter int KI = 5,
  parameter int KP = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clr,
  input  logic                   en,
  input  logic [PW-1:0]          init_in,
  input  logic signed [EW-1:0]   err,
  output logic [PW-1:0]          inc,
  output logic signed [PW+KI-1:0] integ
);
  localparam int INTW = PW + KI;
  localparam logic signed [INTW:0] HI = $signed({2'b00, {(INTW-1){1'b1}}});
  localparam logic signed [INTW:0] LO = $signed({2'b11, {(INTW-1){1'b0}}});

  logic [PW-1:0]          init_q;
  logic signed [INTW-1:0] integ_q;
  logic signed [INTW:0]   sum;
  logic signed [INTW-1:0] sum_sat;

  assign sum = (INTW+1)'(integ_q) + (INTW+1)'(err);

  always_comb begin
    if (sum > HI)      sum_sat = INTW'(HI);
    else if (sum < LO) sum_sat = INTW'(LO);
    else               sum_sat = INTW'(sum);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      init_q  <= '0;
      integ_q <= '0;
    end else if (clr) begin
      init_q  <= init_in;
      integ_q <= '0;
    end else if (en) begin
      integ_q <= sum_sat;
    end
  end

  assign inc   = init_q + PW'(integ_q >>> KI) + (PW'(err) <<< KP);
  assign integ = integ_q;
endmodule

// File: rtl/pilot_tracker.sv
module pilot_tracker #(
  parameter int DW = 12,
  parameter int PW = 20,
  parameter int TW = 10,
  parameter int SW = 12,
  parameter int KA = 3,
  parameter int KB = 3,
  parameter int FR = 4,
  parameter int KI = 5,
  parameter int KP = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 preset,
  input  logic [PW-1:0]        init_inc,
  input  logic                 s_valid,
  output logic                 s_ready,
  input  logic signed [DW-1:0] s_data,
  output logic [PW-1:0]        inc_out
);
  localparam int MW   = DW + 1;
  localparam int EW   = MW + 1;
  localparam int PRW  = DW + SW;
  localparam int INTW = PW + KI;

  logic                  accept;
  logic signed [SW-1:0]  sin_w;
  logic signed [SW-1:0]  cos_w;
  logic signed [PRW-1:0] prod [2];
  logic signed [MW-1:0]  mix  [2];
  logic signed [MW-1:0]  lpfa [2];
  logic signed [MW-1:0]  lpfb;
  logic signed [EW-1:0]  err_w;
  logic signed [INTW-1:0] integ_w;

  assign s_ready = !preset;
  assign accept  = s_valid && s_ready;

  pilot_nco #(.PW(PW), .TW(TW), .SW(SW)) u_nco (
    .clk(clk), .rst_n(rst_n), .clr(preset), .adv(accept),
    .inc(inc_out), .sin_o(sin_w), .cos_o(cos_w)
  );

  // path 0: in-phase (x*cos), path 1: quadrature (x*-sin)
  assign prod[0] = PRW'(s_data) * PRW'(cos_w);
  assign prod[1] = PRW'(s_data) * (-PRW'(sin_w));

  for (genvar g = 0; g < 2; g++) begin : g_path
    assign mix[g] = MW'(prod[g] >>> (SW - 1));
    pilot_iir #(.IW(MW), .FR(FR), .K(KA)) u_lpfa (
      .clk(clk), .rst_n(rst_n), .clr(preset), .en(accept),
      .d(mix[g]), .y(lpfa[g])
    );
  end

  pilot_iir #(.IW(MW), .FR(FR), .K(KB)) u_lpfb (
    .clk(clk), .rst_n(rst_n), .clr(preset), .en(accept),
    .d(lpfa[0]), .y(lpfb)
  );

  assign err_w = lpfb[MW-1] ? -EW'(lpfa[1]) : EW'(lpfa[1]);

  pilot_loop_filter #(.PW(PW), .EW(EW), .KI(KI), .KP(KP)) u_loop (
    .clk(clk), .rst_n(rst_n), .clr(preset), .en(accept),
    .init_in(init_inc), .err(err_w), .inc(inc_out), .integ(integ_w)
  );
endmodule

// File: rtl/pilot_tracker_chk.sv
module pilot_tracker_chk #(
  parameter int DW   = 12,
  parameter int PW   = 20,
  parameter int INTW = 25,
  parameter int EW   = 14
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   preset,
  input logic [PW-1:0]          init_inc,
  input logic                   s_valid,
  input logic                   s_ready,
  input logic signed [DW-1:0]   s_data,
  input logic [PW-1:0]          inc_out,
  input logic signed [INTW-1:0] integ,
  input logic signed [EW-1:0]   err
);
  logic          accept;
  logic          clean_q;
  logic [PW-1:0] held_q;

  assign accept = s_valid && s_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clean_q <= 1'b0;
      held_q  <= '0;
    end else if (preset) begin
      clean_q <= 1'b1;
      held_q  <= init_inc;
    end else if (accept && s_data != '0) begin
      clean_q <= 1'b0;
    end
  end

  assert_ready_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    preset |-> !s_ready);

  assert_preset_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    preset |=> inc_out == $past(init_inc));

  assert_zero_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (clean_q && !preset) |-> inc_out == held_q);

  assert_idle_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!preset && !accept) |=> $stable(inc_out));

  assert_integ_up_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && err >= 0) |=> integ >= $past(integ));

  assert_integ_down_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && err <= 0) |=> integ <= $past(integ));
endmodule

bind pilot_tracker pilot_tracker_chk #(
  .DW(DW), .PW(PW), .INTW(PW + KI), .EW(DW + 2)
) u_chk (
  .clk(clk), .rst_n(rst_n), .preset(preset), .init_inc(init_inc),
  .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
  .inc_out(inc_out), .integ(integ_w), .err(err_w)
);

// File: tb/pilot_tracker_bench.sv
`timescale 1ns/1ps
module pilot_tracker_bench;
  localparam int DW = 12;
  localparam int PW = 20;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic                 preset = 1'b0;
  logic [PW-1:0]        init_inc = '0;
  logic                 s_valid = 1'b0;
  logic                 s_ready;
  logic signed [DW-1:0] s_data = '0;
  logic [PW-1:0]        inc_out;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pilot_tracker u_pilot_tracker (
    .clk(clk), .rst_n(rst_n), .preset(preset), .init_inc(init_inc),
    .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data), .inc_out(inc_out)
  );

  // start values and zero-sample counts for the table walk (R2, R4)
  localparam int NV = 6;
  localparam logic [PW-1:0] V_INIT [NV] = '{20'h10000, 20'h00000, 20'hFFFFF,
                                            20'h00001, 20'h80000, 20'h3A5C7};
  localparam int V_LEN [NV] = '{50, 10, 30, 5, 40, 64};

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // called at posedge+1; leaves inputs quiet at posedge+2
  task automatic do_preset(input logic [PW-1:0] v);
    preset = 1'b1; init_inc = v; s_valid = 1'b1; s_data = 12'sd700;
    #1 check(s_ready == 1'b0, "R3 ready in preset", longint'(s_ready), 0);
    @(posedge clk); #1;
    preset = 1'b0; s_valid = 1'b0; init_inc = ~v;
    #1 check(inc_out == v, "R2 preset load", longint'(inc_out), longint'(v));
  endtask

  task automatic push(input logic signed [DW-1:0] x);
    s_valid = 1'b1; s_data = x;
    @(posedge clk); #1;
    s_valid = 1'b0;
  endtask

  task automatic run_tone(input logic [PW-1:0] init, input longint tone, input string req);
    real ph;
    real step;
    longint sum;
    longint mean;
    logic [PW-1:0] snap;
    ph = 0.0;
    step = 2.0 * 3.14159265358979 * real'(tone) / real'(longint'(1) << PW);
    sum = 0;
    do_preset(init);
    for (int n = 0; n < 6000; n++) begin
      push(12'($rtoi(1000.0 * $cos(ph))));
      ph += step;
    end
    for (int n = 0; n < 512; n++) begin
      push(12'($rtoi(1000.0 * $cos(ph))));
      ph += step;
      #1 sum += longint'(inc_out);
    end
    mean = sum / 512;
    check((mean - tone < 2048) && (tone - mean < 2048), req, mean, tone);
    // R5: stall with garbage data, estimate must not move
    snap = inc_out;
    for (int n = 0; n < 20; n++) begin
      s_valid = 1'b0; s_data = 12'(n * 97 - 900);
      @(posedge clk); #1;
    end
    check(inc_out == snap, "R5 stall hold", longint'(inc_out), longint'(snap));
    // R2: re-preset while tracking returns to start value at once
    do_preset(init);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #1;
    check(inc_out == '0, "R1 reset inc", longint'(inc_out), 0);
    check(s_ready == 1'b1, "R1 reset ready", longint'(s_ready), 1);
    @(posedge clk); #1;

    // table walk: preset then zero samples must hold the start value (R2, R4)
    for (int i = 0; i < NV; i++) begin
      do_preset(V_INIT[i]);
      for (int n = 0; n < V_LEN[i]; n++) push('0);
      #1 check(inc_out == V_INIT[i], "R4 zero input hold",
               longint'(inc_out), longint'(V_INIT[i]));
    end

    // R3: offered sample during preset, ready low, stream quiet after
    @(posedge clk); #1;
    preset = 1'b1; s_valid = 1'b1; s_data = -12'sd2000; init_inc = 20'h12345;
    #1 check(s_ready == 1'b0, "R3 ready low", longint'(s_ready), 0);
    @(posedge clk); #1;
    preset = 1'b0; s_valid = 1'b0;
    #1 check(s_ready == 1'b1, "R3 ready back", longint'(s_ready), 1);

    run_tone(20'd65536, 69632, "R6 track above");
    run_tone(20'd65536, 61440, "R7 track below");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule